// File: doc/BRIEF.md
# Zero-Overhead Loop Micro-Sequencer

This block is a compact program sequencer that needs no arithmetic unit. A program counter addresses a 128-word program store of 36-bit words. Each word carries a flow opcode, two address fields, an 8-bit iteration count, a flag selector and eight user control bits. The control bits appear on `ctrl_o` in the cycle in which their word is addressed. These bits steer a separate data path, which is outside this block.

Counted loops and subroutine calls use one hardware frame stack. A loop instruction names the first and last address of a body and a repeat count. The sequencer then wraps from the last address back to the first without spending any cycle, and leaves after the final pass. A call pushes a frame that runs its region once. When the region's last address executes, control returns to the word after the call. No return instruction exists. Frames nest up to 128 levels deep. A further push is dropped and raises a sticky error flag. Conditional branches test one of eight external condition inputs and may jump anywhere, including backwards.

Top module: `zol_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the sequencer returns to its initial state: `pc_o` is 0, the frame stack is empty and `ovf_o` is 0. This holds whatever state it was in before.
- R2: Word layout: bits 35:33 are the opcode, 32:26 the last address of the region, 25:19 the target or first address, 18:11 the count, 10:8 the flag select and 7:0 the control bits. Opcodes: 0 NOP, 1 FOR, 2 CALL, 3 JMP, 4 branch-if-set, 5 branch-if-clear, 6 HALT, 7 behaves as NOP. `ctrl_o` always equals bits 7:0 of the word at `pc_o`. A NOP moves `pc_o` to the next address, modulo 128.
- R3: FOR with count n ≥ 1 moves to the first address at once. The body then runs exactly n times, wrapping with no extra cycle. After the final pass of the last address, execution continues at the last address plus one.
- R4: FOR with count 0 pushes nothing and goes straight to the last address plus one. The body never executes.
- R5: CALL pushes a frame that returns to the call address plus one. The frame moves `pc_o` to the target. When the frame's last address executes, `pc_o` becomes that return address.
- R6: Frames nest. An inner loop inside an outer body completes all its passes on every outer pass.
- R7: While a frame is active and `pc_o` equals its last address, the loop/return decision sets the next address, and the opcode of that word is ignored.
- R8: JMP moves `pc_o` to the target address unconditionally.
- R9: Branch-if-set jumps to the target when `cond_i[select]` is 1, and branch-if-clear jumps when it is 0. Otherwise the branch falls through to the next address.
- R10: HALT holds `pc_o` at its own address.
- R11: The stack holds up to 128 frames. A FOR or CALL issued with 128 frames active is dropped: it sets `ovf_o`, advances `pc_o` by one and leaves the stack intact. `ovf_o` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | 8 | External condition flags tested by branches |
| ctrl_o | output | 8 | Control bits of the current word |
| pc_o | output | 7 | Current program address |
| ovf_o | output | 1 | Sticky frame-stack overflow flag |

## Verification
The bench runs a test program that contains each flow case in turn. Nested counted loops with distinct repeat counts separate correct wrap counts from off-by-one errors. A zero-count loop guards a region that must never be entered. A call to a three-word region checks the return point, and a one-pass loop whose last word is a jump shows that the end check has priority over the opcode. A self-calling region fills the stack to its limit, and the unwinding that follows checks both the dropped push and every return address. The program runs twice under opposite condition-flag settings, so that each branch polarity is seen both taken and not taken. Each cycle is compared with a queue-based model, and the number of visits to chosen addresses is also checked.

// File: rtl/zol_pkg.sv
package zol_pkg;

    localparam int ADDR_W     = 7;
    localparam int PROG_DEPTH = 1 << ADDR_W;
    localparam int CNT_W      = 8;
    localparam int SEL_W      = 3;
    localparam int NFLAG      = 1 << SEL_W;
    localparam int CTRL_W     = 8;
    localparam int OP_W       = 3;
    localparam int WORD_W     = OP_W + 2 * ADDR_W + CNT_W + SEL_W + CTRL_W;
    localparam int IMAGE_W    = PROG_DEPTH * WORD_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [CTRL_W-1:0] ctrl_t;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 3'd0,
        OP_FOR  = 3'd1,
        OP_CALL = 3'd2,
        OP_JMP  = 3'd3,
        OP_BRS  = 3'd4,
        OP_BRC  = 3'd5,
        OP_HALT = 3'd6,
        OP_RSV  = 3'd7
    } op_e;

    // One program word; field order fixes the bit positions.
    typedef struct packed {
        op_e   op;
        addr_t last;
        addr_t target;
        cnt_t  count;
        sel_t  sel;
        ctrl_t ctrl;
    } instr_t;

    // One loop/call frame on the hardware stack.
    typedef struct packed {
        addr_t first;
        addr_t last;
        addr_t resume;
        cnt_t  left;
    } frame_t;

    function automatic instr_t make_instr(op_e op, int last, int target,
                                          int count, int sel, int ctrl);
        instr_t w;
        w.op     = op;
        w.last   = addr_t'(last);
        w.target = addr_t'(target);
        w.count  = cnt_t'(count);
        w.sel    = sel_t'(sel);
        w.ctrl   = ctrl_t'(ctrl);
        return w;
    endfunction

    // Small default program: a counted loop followed by a halt.
    function automatic logic [IMAGE_W-1:0] demo_image();
        logic [IMAGE_W-1:0] img;
        img = '0;
        for (int a = 0; a < PROG_DEPTH; a++) begin
            img[a*WORD_W +: WORD_W] = make_instr(OP_NOP, 0, 0, 0, 0, a);
        end
        img[1*WORD_W +: WORD_W] = make_instr(OP_FOR, 3, 2, 4, 0, 8'h10);
        img[2*WORD_W +: WORD_W] = make_instr(OP_NOP, 0, 0, 0, 0, 8'h21);
        img[3*WORD_W +: WORD_W] = make_instr(OP_NOP, 0, 0, 0, 0, 8'h42);
        img[4*WORD_W +: WORD_W] = make_instr(OP_HALT, 0, 0, 0, 0, 8'h80);
        return img;
    endfunction

endpackage

// File: rtl/zol_prog_rom.sv
module zol_prog_rom
    import zol_pkg::*;
#(
    parameter logic [IMAGE_W-1:0] IMAGE = demo_image()
) (
    input  addr_t  addr,
    output instr_t word
);

    logic [WORD_W-1:0] mem [PROG_DEPTH];

    generate
        for (genvar i = 0; i < PROG_DEPTH; i++) begin : g_word
            assign mem[i] = IMAGE[i*WORD_W +: WORD_W];
        end
    endgenerate

    assign word = instr_t'(mem[addr]);

endmodule

// File: rtl/zol_frame_stack.sv
module zol_frame_stack
    import zol_pkg::*;
#(
    parameter  int STACK_DEPTH = 128,
    localparam int DW = $clog2(STACK_DEPTH + 1),
    localparam int MW = $clog2(STACK_DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic          dec,
    input  frame_t        push_frame,
    output frame_t        tos,
    output logic [DW-1:0] depth,
    output logic          full,
    output logic          empty
);

    // Top frame lives in a register; lower frames sit in the array.
    frame_t          tos_q;
    logic [DW-1:0]   depth_q;
    frame_t          below [STACK_DEPTH];
    logic [MW-1:0]   wr_idx;
    logic [MW-1:0]   rd_idx;

    assign wr_idx = MW'(depth_q - DW'(1));
    assign rd_idx = MW'(depth_q - DW'(2));

    always_ff @(posedge clk) begin
        if (rst) begin
            tos_q   <= '0;
            depth_q <= '0;
        end else if (push) begin
            if (depth_q != '0) begin
                below[wr_idx] <= tos_q;
            end
            tos_q   <= push_frame;
            depth_q <= depth_q + DW'(1);
        end else if (pop) begin
            if (depth_q > DW'(1)) begin
                tos_q <= below[rd_idx];
            end else begin
                tos_q <= '0;
            end
            depth_q <= depth_q - DW'(1);
        end else if (dec) begin
            tos_q.left <= tos_q.left - cnt_t'(1);
        end
    end

    assign tos   = tos_q;
    assign depth = depth_q;
    assign full  = (depth_q == DW'(STACK_DEPTH));
    assign empty = (depth_q == '0);

endmodule

// File: rtl/zol_flow.sv
module zol_flow
    import zol_pkg::*;
(
    input  addr_t             pc,
    input  instr_t            instr,
    input  logic [NFLAG-1:0]  flags,
    input  frame_t            tos,
    input  logic              stack_empty,
    input  logic              stack_full,
    output addr_t             next_pc,
    output logic              push,
    output logic              pop,
    output logic              dec,
    output frame_t            new_frame,
    output logic              ovf_hit
);

    addr_t seq_pc;
    addr_t after_last;
    logic  at_end;
    logic  flag_bit;

    assign seq_pc     = pc + addr_t'(1);
    assign after_last = instr.last + addr_t'(1);
    assign at_end     = !stack_empty && (pc == tos.last);
    assign flag_bit   = flags[instr.sel];

    always_comb begin
        next_pc   = seq_pc;
        push      = 1'b0;
        pop       = 1'b0;
        dec       = 1'b0;
        ovf_hit   = 1'b0;
        new_frame = '0;
        if (at_end) begin
            // End-address decision overrides the word's own opcode.
            if (tos.left != '0) begin
                dec     = 1'b1;
                next_pc = tos.first;
            end else begin
                pop     = 1'b1;
                next_pc = tos.resume;
            end
        end else begin
            case (instr.op)
                OP_FOR: begin
                    if (instr.count == '0) begin
                        next_pc = after_last;
                    end else if (stack_full) begin
                        ovf_hit = 1'b1;
                    end else begin
                        push      = 1'b1;
                        new_frame = '{first:  instr.target,
                                      last:   instr.last,
                                      resume: after_last,
                                      left:   instr.count - cnt_t'(1)};
                        next_pc   = instr.target;
                    end
                end
                OP_CALL: begin
                    if (stack_full) begin
                        ovf_hit = 1'b1;
                    end else begin
                        push      = 1'b1;
                        new_frame = '{first:  instr.target,
                                      last:   instr.last,
                                      resume: seq_pc,
                                      left:   '0};
                        next_pc   = instr.target;
                    end
                end
                OP_JMP:  next_pc = instr.target;
                OP_BRS:  next_pc = flag_bit ? instr.target : seq_pc;
                OP_BRC:  next_pc = flag_bit ? seq_pc : instr.target;
                OP_HALT: next_pc = pc;
                default: next_pc = seq_pc;
            endcase
        end
    end

endmodule

// File: rtl/zol_seq.sv
module zol_seq
    import zol_pkg::*;
#(
    parameter  int                 STACK_DEPTH = 128,
    parameter  logic [IMAGE_W-1:0] IMAGE       = demo_image(),
    localparam int                 DEPTH_W     = $clog2(STACK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NFLAG-1:0]  cond_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic              ovf_o
);

    addr_t               pc_q;
    addr_t               next_pc;
    instr_t              cur_w;
    frame_t              tos_w;
    frame_t              new_frame;
    logic [DEPTH_W-1:0]  depth_w;
    logic                push;
    logic                pop;
    logic                dec;
    logic                full;
    logic                empty;
    logic                ovf_hit;
    logic                ovf_q;

    zol_prog_rom #(.IMAGE(IMAGE)) u_rom (
        .addr (pc_q),
        .word (cur_w)
    );

    zol_frame_stack #(.STACK_DEPTH(STACK_DEPTH)) u_stack (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .pop        (pop),
        .dec        (dec),
        .push_frame (new_frame),
        .tos        (tos_w),
        .depth      (depth_w),
        .full       (full),
        .empty      (empty)
    );

    zol_flow u_flow (
        .pc          (pc_q),
        .instr       (cur_w),
        .flags       (cond_i),
        .tos         (tos_w),
        .stack_empty (empty),
        .stack_full  (full),
        .next_pc     (next_pc),
        .push        (push),
        .pop         (pop),
        .dec         (dec),
        .new_frame   (new_frame),
        .ovf_hit     (ovf_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ovf_q <= 1'b0;
        end else begin
            pc_q <= next_pc;
            if (ovf_hit) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign ctrl_o = cur_w.ctrl;
    assign pc_o   = pc_q;
    assign ovf_o  = ovf_q;

endmodule

// File: rtl/zol_seq_chk.sv
module zol_seq_chk
    import zol_pkg::*;
#(
    parameter  int STACK_DEPTH = 128,
    localparam int DW = $clog2(STACK_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [ADDR_W-1:0] pc,
    input logic             ovf,
    input instr_t           instr,
    input frame_t           tos,
    input logic [DW-1:0]    depth,
    input logic [NFLAG-1:0] flags
);

    logic at_end;
    assign at_end = (depth != '0) && (pc == tos.last);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == '0 && !ovf && depth == '0));

    a_r2_nop_advance: assert property (@(posedge clk) disable iff (rst)
        (instr.op == OP_NOP && !at_end) |=> pc == addr_t'($past(pc) + 1'b1));

    a_r3_loop_wrap: assert property (@(posedge clk) disable iff (rst)
        (at_end && tos.left != '0) |=> (pc == $past(tos.first) && depth == $past(depth)));

    a_r4_zero_skip: assert property (@(posedge clk) disable iff (rst)
        (instr.op == OP_FOR && instr.count == '0 && !at_end)
        |=> (pc == addr_t'($past(instr.last) + 1'b1) && depth == $past(depth)));

    a_r5_return: assert property (@(posedge clk) disable iff (rst)
        (at_end && tos.left == '0) |=> (pc == $past(tos.resume) && depth == DW'($past(depth) - 1'b1)));

    a_r6_nest_push: assert property (@(posedge clk) disable iff (rst)
        (instr.op == OP_FOR && instr.count != '0 && !at_end && depth < DW'(STACK_DEPTH))
        |=> depth == DW'($past(depth) + 1'b1));

    a_r8_jump: assert property (@(posedge clk) disable iff (rst)
        (instr.op == OP_JMP && !at_end) |=> pc == $past(instr.target));

    a_r9_branch_set: assert property (@(posedge clk) disable iff (rst)
        (instr.op == OP_BRS && !at_end && flags[instr.sel]) |=> pc == $past(instr.target));

    a_r10_halt_hold: assert property (@(posedge clk) disable iff (rst)
        (instr.op == OP_HALT && !at_end) |=> $stable(pc));

    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    a_r11_depth_cap: assert property (@(posedge clk) disable iff (rst)
        depth <= DW'(STACK_DEPTH));

    a_r11_ovf_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(depth) == DW'(STACK_DEPTH));

endmodule

bind zol_seq zol_seq_chk #(.STACK_DEPTH(STACK_DEPTH)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .pc    (pc_o),
    .ovf   (ovf_o),
    .instr (cur_w),
    .tos   (tos_w),
    .depth (depth_w),
    .flags (cond_i)
);

// File: tb/zol_seq_bench.sv
module zol_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 128;
    localparam int WBITS      = 36;
    localparam int LEVELS     = 128;
    localparam int RUN_CYCLES = 400;
    localparam int WATCHDOG   = 20000;

    localparam int K_NOP = 0, K_FOR = 1, K_CALL = 2, K_JMP = 3;
    localparam int K_BRS = 4, K_BRC = 5, K_HALT = 6;

    function automatic logic [WBITS-1:0] enc(int op, int last, int tgt,
                                             int cnt, int sel, int ctrl);
        logic [WBITS-1:0] w;
        w[35:33] = 3'(op);
        w[32:26] = 7'(last);
        w[25:19] = 7'(tgt);
        w[18:11] = 8'(cnt);
        w[10:8]  = 3'(sel);
        w[7:0]   = 8'(ctrl);
        return w;
    endfunction

    function automatic logic [WORDS*WBITS-1:0] build_prog();
        logic [WORDS*WBITS-1:0] p;
        p = '0;
        for (int a = 0; a < WORDS; a++) p[a*WBITS +: WBITS] = enc(K_NOP, 0, 0, 0, 0, a ^ 8'h5A);
        p[1*WBITS  +: WBITS] = enc(K_FOR, 5, 2, 3, 0, 8'h01);   // outer loop 2..5 x3
        p[3*WBITS  +: WBITS] = enc(K_FOR, 4, 4, 2, 0, 8'h03);   // inner loop 4..4 x2
        p[6*WBITS  +: WBITS] = enc(K_FOR, 8, 7, 0, 0, 8'h06);   // zero-count skip
        p[7*WBITS  +: WBITS] = enc(K_JMP, 0, 100, 0, 0, 8'h07);
        p[8*WBITS  +: WBITS] = enc(K_JMP, 0, 100, 0, 0, 8'h08);
        p[9*WBITS  +: WBITS] = enc(K_CALL, 42, 40, 0, 0, 8'h09);
        p[10*WBITS +: WBITS] = enc(K_BRS, 0, 12, 0, 2, 8'h0A);
        p[12*WBITS +: WBITS] = enc(K_BRC, 0, 14, 0, 5, 8'h0C);
        p[14*WBITS +: WBITS] = enc(K_JMP, 0, 16, 0, 0, 8'h0E);
        p[15*WBITS +: WBITS] = enc(K_HALT, 0, 0, 0, 0, 8'h0F);
        p[16*WBITS +: WBITS] = enc(K_FOR, 17, 17, 1, 0, 8'h10);
        p[17*WBITS +: WBITS] = enc(K_JMP, 0, 100, 0, 0, 8'h11);  // ignored at loop end
        p[18*WBITS +: WBITS] = enc(K_CALL, 61, 60, 0, 0, 8'h12);
        p[19*WBITS +: WBITS] = enc(K_HALT, 0, 0, 0, 0, 8'h13);
        p[60*WBITS +: WBITS] = enc(K_CALL, 61, 60, 0, 0, 8'h3C); // self call fills stack
        return p;
    endfunction

    localparam logic [WORDS*WBITS-1:0] PROG = build_prog();

    typedef struct {
        int first;
        int last;
        int resume;
        int left;
    } frame_s;

    logic       clk;
    logic       rst;
    logic [7:0] cond;
    logic [7:0] ctrl_o;
    logic [6:0] pc_o;
    logic       ovf_o;

    int     n_checks;
    int     n_fail;
    int     mpc;
    bit     movf;
    frame_s stk[$];
    int     visits[WORDS];

    zol_seq #(.IMAGE(PROG)) u_zol_seq (
        .clk    (clk),
        .rst    (rst),
        .cond_i (cond),
        .ctrl_o (ctrl_o),
        .pc_o   (pc_o),
        .ovf_o  (ovf_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        logic [WBITS-1:0] w;
        int op, last, tgt, cnt, sel;
        frame_s f;
        w    = PROG[mpc*WBITS +: WBITS];
        op   = int'(w[35:33]);
        last = int'(w[32:26]);
        tgt  = int'(w[25:19]);
        cnt  = int'(w[18:11]);
        sel  = int'(w[10:8]);
        if (stk.size() != 0 && stk[stk.size()-1].last == mpc) begin
            f = stk[stk.size()-1];
            if (f.left > 0) begin
                f.left--;
                stk[stk.size()-1] = f;
                mpc = f.first;
            end else begin
                mpc = f.resume;
                void'(stk.pop_back());
            end
        end else begin
            case (op)
                K_FOR: begin
                    if (cnt == 0) mpc = (last + 1) % WORDS;
                    else if (stk.size() == LEVELS) begin movf = 1; mpc = (mpc + 1) % WORDS; end
                    else begin
                        f.first = tgt; f.last = last; f.resume = (last + 1) % WORDS; f.left = cnt - 1;
                        stk.push_back(f);
                        mpc = tgt;
                    end
                end
                K_CALL: begin
                    if (stk.size() == LEVELS) begin movf = 1; mpc = (mpc + 1) % WORDS; end
                    else begin
                        f.first = tgt; f.last = last; f.resume = (mpc + 1) % WORDS; f.left = 0;
                        stk.push_back(f);
                        mpc = tgt;
                    end
                end
                K_JMP:  mpc = tgt;
                K_BRS:  mpc = cond[sel] ? tgt : (mpc + 1) % WORDS;
                K_BRC:  mpc = cond[sel] ? (mpc + 1) % WORDS : tgt;
                K_HALT: mpc = mpc;
                default: mpc = (mpc + 1) % WORDS;
            endcase
        end
    endtask

    task automatic run_prog(logic [7:0] flags, bit set_a);
        rst  = 1'b1;
        cond = flags;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: state right after reset
        check(pc_o == 7'd0, "R1", "pc after reset", int'(pc_o), 0);
        check(ovf_o == 1'b0, "R1", "ovf after reset", int'(ovf_o), 0);
        mpc  = 0;
        movf = 0;
        stk.delete();
        for (int a = 0; a < WORDS; a++) visits[a] = 0;
        for (int c = 0; c < RUN_CYCLES; c++) begin
            visits[pc_o]++;
            // R2: per-cycle comparison with the reference model
            check(int'(pc_o) == mpc, "R2", "pc trace", int'(pc_o), mpc);
            check(ctrl_o == PROG[mpc*WBITS +: 8], "R2", "ctrl trace",
                  int'(ctrl_o), int'(PROG[mpc*WBITS +: 8]));
            check(ovf_o == movf, "R11", "ovf trace", int'(ovf_o), int'(movf));
            model_step();
            @(negedge clk);
        end
        check(visits[2] == 3, "R3", "outer body passes", visits[2], 3);
        check(visits[5] == 3, "R3", "outer last-address passes", visits[5], 3);
        check(visits[4] == 6, "R6", "inner body passes", visits[4], 6);
        check(visits[7] + visits[8] == 0, "R4", "skipped body entries", visits[7] + visits[8], 0);
        check(visits[41] == 1, "R5", "subroutine body runs", visits[41], 1);
        check(visits[10] == 1, "R5", "return point reached", visits[10], 1);
        check(visits[100] == 0, "R7", "jump at loop end taken", visits[100], 0);
        check(visits[18] == 1, "R7", "continue after one-pass loop", visits[18], 1);
        check(visits[15] == 0 && visits[16] == 1, "R8", "jump landing", visits[16], 1);
        check(visits[11] == (set_a ? 0 : 1), "R9", "branch-if-set fall through", visits[11], set_a ? 0 : 1);
        check(visits[13] == (set_a ? 0 : 1), "R9", "branch-if-clear fall through", visits[13], set_a ? 0 : 1);
        check(visits[60] == LEVELS, "R11", "pushes before overflow", visits[60], LEVELS);
        check(visits[61] == LEVELS, "R11", "unwinding returns", visits[61], LEVELS);
        check(ovf_o == 1'b1, "R11", "sticky overflow", int'(ovf_o), 1);
        check(pc_o == 7'd19, "R10", "halt address", int'(pc_o), 19);
        @(negedge clk);
        check(pc_o == 7'd19, "R10", "halt holds", int'(pc_o), 19);
    endtask

    initial begin
        n_checks = 0;
        n_fail   = 0;
        rst      = 1'b1;
        cond     = 8'h00;
        run_prog(8'h04, 1'b1);
        run_prog(8'h20, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule